// File: doc/BRIEF.md
# Codec Control Register Bank

This block holds the six 8-bit control registers of a voice-band codec and turns their contents into decoded control fields for the codec datapath: power state, sidetone routing, sample format, filter and microphone selection, transmit, sidetone and receive gain codes, and the two tone frequency codes. A plain register port stands in for the two-wire serial slave. It takes a one-cycle write strobe, a register address and write data, and it returns read data for the addressed register.

A strapping input selects the start-up policy. It is sampled on the first clock edge after reset is released. When the strap is high, the bank enters a self-running default mode. The power register is loaded with a value that powers the codec up with sidetone on, every other register keeps its reset default, and host writes have no effect. When the strap is low, the codec stays powered down until the host writes the power register with the power-up bit set.

Register map, with the power register at address 0 and the two tone registers at 4 (high tone) and 5 (low tone):

| Addr | Contents |
|------|----------|
| 0 | bit0 power up, bit1 sidetone enable, bit7 deep power-down select |
| 1 | bit0 linear samples (0 = companded), bit1 A-law (0 = µ-law), bit2 receive high-pass enable, bit3 microphone 2 select, bit4 second microphone stage boost |
| 2 | bits 3:0 transmit attenuation code (0 = 0 dB), bits 6:4 sidetone attenuation code (0 = −12 dB) |
| 3 | bits 3:0 receive volume code in 2 dB steps (0 = 0 dB, 9 = −18 dB), bit4 receive gain select (0 = −1 dB, 1 = −2 dB) |
| 4 | high-tone frequency code |
| 5 | low-tone frequency code |

Top module: `codec_ctrl_regs`

## Requirements
- R1: While rst_n is low, every register reads 0x00, the power output is 0 and the default-mode flag is 0. A zero code means 0 dB transmit, −12 dB sidetone, 0 dB volume and −1 dB receive gain.
- R2: With the strap high on the first clock edge after reset is released, the default-mode flag goes to 1 and stays at 1 until the next reset. From that edge on, address 0 reads 0x03, so the codec is powered up with sidetone enabled.
- R3: In default mode, a write to any address leaves every register and every decoded output unchanged.
- R4: With the strap low, the power output stays 0 after reset and through writes to the other addresses. From then on it follows bit 0 of the last value written to address 0.
- R5: A write to address 0 to 5, made outside default mode, is visible on read data and on the decoded outputs from the clock edge that accepts the strobe. Writes are not accepted in the first cycle after reset.
- R6: Writes to addresses 6 and 7 have no effect, and those addresses read 0x00.
- R7: A receive volume code above 9 is stored and driven as 9 (−18 dB). Bits 7:4 of address 3 are stored unchanged.
- R8: The sidetone enable output is bit1 AND bit0 of address 0. The deep power-down output is bit7 AND NOT bit0 of address 0.
- R9: The sample-format, high-pass, microphone select and boost outputs follow bits 0 to 4 of address 1 as mapped above.
- R10: The high-tone and low-tone outputs carry all 8 bits of addresses 4 and 5.
- R11: The transmit attenuation, sidetone attenuation and receive gain select outputs follow the fields of addresses 2 and 3 as mapped above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_default_i | input | 1 | Start-up policy strap: 1 = default mode, 0 = wait for host |
| wr_en_i | input | 1 | One-cycle write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| fixed_mode_o | output | 1 | Default mode is active |
| pwr_active_o | output | 1 | Codec powered up |
| deep_pd_o | output | 1 | Deep power-down selected while powered down |
| sidetone_en_o | output | 1 | Sidetone path enabled |
| linear_o | output | 1 | Linear sample format |
| alaw_o | output | 1 | A-law companding |
| rx_hpf_en_o | output | 1 | Receive high-pass filter enabled |
| mic_sel_o | output | 1 | Microphone 2 selected |
| mic_boost_o | output | 1 | Second microphone stage boost |
| tx_atten_o | output | 4 | Transmit attenuation code |
| side_atten_o | output | 3 | Sidetone attenuation code |
| rx_vol_o | output | 4 | Receive volume code, saturated at 9 |
| rx_gain_low_o | output | 1 | Receive gain −2 dB selected |
| tone_hi_o | output | 8 | High-tone frequency code |
| tone_lo_o | output | 8 | Low-tone frequency code |

## Verification
The bench builds the block with its default ten volume steps, so the saturation threshold sits at code 9. An 8-bit register space is small enough to sweep completely. In both strap settings, every one of the 256 data values is written to every one of the eight addresses, and a bench model predicts read data and every decoded field after each write. This covers every saturating volume code, every power and sidetone bit combination, and the reserved addresses. It also reaches the ordering case where the other addresses are written before the power register is.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned REG_COUNT = 6;

  // register indices; the tone positions are fixed by the host software map
  localparam int unsigned PWR_IDX  = 0;
  localparam int unsigned MODE_IDX = 1;
  localparam int unsigned TXG_IDX  = 2;
  localparam int unsigned RXG_IDX  = 3;
  localparam int unsigned TONH_IDX = 4;
  localparam int unsigned TONL_IDX = 5;

  // power register bit positions
  localparam int unsigned PWR_ON_BIT   = 0;
  localparam int unsigned PWR_SIDE_BIT = 1;
  localparam int unsigned PWR_DEEP_BIT = 7;

  // power value forced by the strap-selected default mode
  localparam logic [REG_W-1:0] FIXED_PWR_VAL = 8'h03;

  typedef logic [REG_COUNT-1:0][REG_W-1:0] reg_bank_t;

  // clamp the low volume nibble to the deepest valid step
  function automatic logic [REG_W-1:0] clamp_vol(input logic [REG_W-1:0] d,
                                                 input logic [3:0] max_code);
    logic [REG_W-1:0] r;
    r = d;
    if (d[3:0] > max_code) r[3:0] = max_code;
    return r;
  endfunction

endpackage

// File: rtl/codec_boot_ctl.sv
module codec_boot_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic boot_load_o,
  output logic fixed_o
);

  logic boot_done_q, boot_done_d;
  logic fixed_q, fixed_d;

  always_comb begin
    boot_done_d = boot_done_q;
    fixed_d     = fixed_q;
    if (!boot_done_q) begin
      boot_done_d = 1'b1;
      fixed_d     = strap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_done_q <= 1'b0;
      fixed_q     <= 1'b0;
    end else begin
      boot_done_q <= boot_done_d;
      fixed_q     <= fixed_d;
    end
  end

  assign boot_load_o = !boot_done_q;
  assign fixed_o     = fixed_q;

  // R2: the strap is sampled once; the mode then holds until reset
  p_strap_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done_q |=> (boot_done_q && $stable(fixed_q)));

endmodule

// File: rtl/codec_reg_file.sv
module codec_reg_file
  import codec_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned VOL_STEPS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_load_i,
  input  logic              strap_i,
  input  logic              fixed_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output reg_bank_t         regs_o
);

  localparam logic [3:0] VOL_MAX = 4'(VOL_STEPS - 1);

  reg_bank_t regs_q, regs_d;
  logic      wr_ok;

  assign wr_ok = wr_en_i && !boot_load_i && !fixed_i;

  always_comb begin
    regs_d = regs_q;
    if (boot_load_i && strap_i) regs_d[PWR_IDX] = FIXED_PWR_VAL;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (wr_ok && addr_i == ADDR_W'(i)) begin
        if (i == RXG_IDX) regs_d[i] = clamp_vol(wdata_i, VOL_MAX);
        else              regs_d[i] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign regs_o = regs_q;

  // R3: default mode freezes the whole bank
  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_i |=> $stable(regs_q));

  // R7: the stored volume code never exceeds the deepest step
  p_vol_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[RXG_IDX][3:0] <= VOL_MAX);

  // R5: an accepted tone write lands on the next edge
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !boot_load_i && !fixed_i && addr_i == ADDR_W'(TONH_IDX))
      |=> regs_q[TONH_IDX] == $past(wdata_i));

  // R4: the power register moves only on a write to it or at boot
  p_power_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_load_i && !(wr_en_i && addr_i == ADDR_W'(PWR_IDX)))
      |=> $stable(regs_q[PWR_IDX]));

endmodule

// File: rtl/codec_field_decode.sv
module codec_field_decode
  import codec_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_bank_t regs_i,
  output logic      pwr_active_o,
  output logic      deep_pd_o,
  output logic      sidetone_en_o,
  output logic      linear_o,
  output logic      alaw_o,
  output logic      rx_hpf_en_o,
  output logic      mic_sel_o,
  output logic      mic_boost_o,
  output logic [3:0] tx_atten_o,
  output logic [2:0] side_atten_o,
  output logic [3:0] rx_vol_o,
  output logic      rx_gain_low_o,
  output logic [REG_W-1:0] tone_hi_o,
  output logic [REG_W-1:0] tone_lo_o
);

  logic [REG_W-1:0] pwr;
  assign pwr = regs_i[PWR_IDX];

  always_comb begin
    pwr_active_o  = pwr[PWR_ON_BIT];
    deep_pd_o     = pwr[PWR_DEEP_BIT] && !pwr[PWR_ON_BIT];
    sidetone_en_o = pwr[PWR_SIDE_BIT] && pwr[PWR_ON_BIT];
    linear_o      = regs_i[MODE_IDX][0];
    alaw_o        = regs_i[MODE_IDX][1];
    rx_hpf_en_o   = regs_i[MODE_IDX][2];
    mic_sel_o     = regs_i[MODE_IDX][3];
    mic_boost_o   = regs_i[MODE_IDX][4];
    tx_atten_o    = regs_i[TXG_IDX][3:0];
    side_atten_o  = regs_i[TXG_IDX][6:4];
    rx_vol_o      = regs_i[RXG_IDX][3:0];
    rx_gain_low_o = regs_i[RXG_IDX][4];
    tone_hi_o     = regs_i[TONH_IDX];
    tone_lo_o     = regs_i[TONL_IDX];
  end

  // R8: sidetone and deep power-down never coexist with the wrong power state
  p_side_needs_pwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sidetone_en_o |-> pwr_active_o);
  p_deep_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(deep_pd_o && pwr_active_o));

endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_ctrl_pkg::*;
#(
  parameter int unsigned VOL_STEPS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_default_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       fixed_mode_o,
  output logic       pwr_active_o,
  output logic       deep_pd_o,
  output logic       sidetone_en_o,
  output logic       linear_o,
  output logic       alaw_o,
  output logic       rx_hpf_en_o,
  output logic       mic_sel_o,
  output logic       mic_boost_o,
  output logic [3:0] tx_atten_o,
  output logic [2:0] side_atten_o,
  output logic [3:0] rx_vol_o,
  output logic       rx_gain_low_o,
  output logic [7:0] tone_hi_o,
  output logic [7:0] tone_lo_o
);

  localparam int unsigned ADDR_W = $clog2(REG_COUNT);

  logic      boot_load, fixed;
  reg_bank_t regs;

  codec_boot_ctl u_boot (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap_default_i),
    .boot_load_o (boot_load),
    .fixed_o     (fixed)
  );

  codec_reg_file #(.ADDR_W(ADDR_W), .VOL_STEPS(VOL_STEPS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_load_i (boot_load),
    .strap_i     (strap_default_i),
    .fixed_i     (fixed),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .regs_o      (regs)
  );

  codec_field_decode u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .regs_i        (regs),
    .pwr_active_o  (pwr_active_o),
    .deep_pd_o     (deep_pd_o),
    .sidetone_en_o (sidetone_en_o),
    .linear_o      (linear_o),
    .alaw_o        (alaw_o),
    .rx_hpf_en_o   (rx_hpf_en_o),
    .mic_sel_o     (mic_sel_o),
    .mic_boost_o   (mic_boost_o),
    .tx_atten_o    (tx_atten_o),
    .side_atten_o  (side_atten_o),
    .rx_vol_o      (rx_vol_o),
    .rx_gain_low_o (rx_gain_low_o),
    .tone_hi_o     (tone_hi_o),
    .tone_lo_o     (tone_lo_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = regs[i];
    end
  end

  assign fixed_mode_o = fixed;

  // R6: reserved addresses read zero
  p_rsvd_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i >= ADDR_W'(REG_COUNT)) |-> rdata_o == '0);

  // R2: default mode always shows a powered-up codec
  p_fixed_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_mode_o |-> pwr_active_o);

endmodule

// File: tb/test_codec_ctrl_regs.sv
module test_codec_ctrl_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       fixed_mode, pwr_active, deep_pd, sidetone_en, linear, alaw;
  logic       rx_hpf_en, mic_sel, mic_boost, rx_gain_low;
  logic [3:0] tx_atten, rx_vol;
  logic [2:0] side_atten;
  logic [7:0] tone_hi, tone_lo;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [7:0] mdl [6];
  logic       mdl_fixed;

  always #2 clk = ~clk;

  codec_ctrl_regs i_codec_ctrl_regs (
    .clk (clk), .rst_n (rst_n), .strap_default_i (strap),
    .wr_en_i (wr_en), .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
    .fixed_mode_o (fixed_mode), .pwr_active_o (pwr_active), .deep_pd_o (deep_pd),
    .sidetone_en_o (sidetone_en), .linear_o (linear), .alaw_o (alaw),
    .rx_hpf_en_o (rx_hpf_en), .mic_sel_o (mic_sel), .mic_boost_o (mic_boost),
    .tx_atten_o (tx_atten), .side_atten_o (side_atten), .rx_vol_o (rx_vol),
    .rx_gain_low_o (rx_gain_low), .tone_hi_o (tone_hi), .tone_lo_o (tone_lo)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!mdl_fixed && a < 3'd6) begin
      if (a == 3'd3) mdl[a] = {d[7:4], (d[3:0] > 4'd9) ? 4'd9 : d[3:0]};
      else           mdl[a] = d;
    end
  endtask

  task automatic check_state();
    for (int a = 0; a < 8; a++) begin
      int e;
      addr = 3'(a);
      #1;
      e = (a < 6) ? int'(mdl[a]) : 0;
      if (a >= 6)      chk(rdata == 8'(e), "R6 reserved read", rdata, e);
      else if (a == 3) chk(rdata == 8'(e), "R7 volume readback", rdata, e);
      else if (a >= 4) chk(rdata == 8'(e), "R10 tone readback", rdata, e);
      else             chk(rdata == 8'(e), mdl_fixed ? "R3 frozen readback" : "R5 readback", rdata, e);
    end
    chk(fixed_mode == mdl_fixed, "R2 mode flag", fixed_mode, mdl_fixed);
    chk(pwr_active == mdl[0][0], "R4 power", pwr_active, mdl[0][0]);
    chk(sidetone_en == (mdl[0][1] & mdl[0][0]), "R8 sidetone", sidetone_en, mdl[0][1] & mdl[0][0]);
    chk(deep_pd == (mdl[0][7] & ~mdl[0][0]), "R8 deep pd", deep_pd, mdl[0][7] & ~mdl[0][0]);
    chk({mic_boost, mic_sel, rx_hpf_en, alaw, linear} == mdl[1][4:0], "R9 mode fields",
        {mic_boost, mic_sel, rx_hpf_en, alaw, linear}, mdl[1][4:0]);
    chk(tx_atten == mdl[2][3:0], "R11 tx atten", tx_atten, mdl[2][3:0]);
    chk(side_atten == mdl[2][6:4], "R11 sidetone atten", side_atten, mdl[2][6:4]);
    chk(rx_vol == mdl[3][3:0], "R7 volume out", rx_vol, mdl[3][3:0]);
    chk(rx_gain_low == mdl[3][4], "R11 rx gain", rx_gain_low, mdl[3][4]);
    chk(tone_hi == mdl[4], "R10 high tone", tone_hi, mdl[4]);
    chk(tone_lo == mdl[5], "R10 low tone", tone_lo, mdl[5]);
  endtask

  task automatic apply_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; wr_en = 1'b0;
    for (int i = 0; i < 6; i++) mdl[i] = 8'h00;
    mdl_fixed = 1'b0;
    repeat (2) @(negedge clk);
    check_state();  // R1: zero state while reset is held, strap ignored
    rst_n = 1'b1;
    @(negedge clk);  // boot edge has passed
    if (s) begin
      mdl_fixed = 1'b1;
      mdl[0] = 8'h03;
    end
    check_state();
  endtask

  task automatic sweep();
    for (int a = 7; a >= 0; a--) begin
      for (int d = 0; d < 256; d++) begin
        do_write(3'(a), 8'(d));
        check_state();
      end
      if (a == 1 && !mdl_fixed)  // R4: nothing but address 0 has powered up the codec
        chk(pwr_active == 1'b0, "R4 still down", pwr_active, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    apply_reset(1'b0);
    sweep();
    do_write(3'd3, 8'hFC);  // R7: code 12 clamps to 9, upper nibble kept
    check_state();
    do_write(3'd0, 8'h83);  // R8: powered with sidetone
    check_state();
    apply_reset(1'b1);
    sweep();                // R3: every write ignored
    apply_reset(1'b0);      // R1: reset after activity returns defaults
    finish_run();
  end

endmodule